// File: doc/BRIEF.md
# DRAM Mode-Register Timing Tracker

This controller-side block watches writes to the first DRAM mode register and turns the stored fields into live values and waits. It reports the read latency, which is the additive latency plus the CAS latency. It reports the write-to-precharge delay for auto-precharge writes. It raises level error flags for two settings: the vendor test-mode bit, and a write-recovery setting shorter than the timing minimum.

Two state machines track the settings that need a wait. The DLL machine has the states DLL_NEED_RST, DLL_LOCKING and DLL_LOCKED:
- DLL_NEED_RST moves to DLL_LOCKING when a register write carries the DLL-reset bit.
- DLL_LOCKED also moves to DLL_LOCKING on that bit.
- DLL_LOCKING restarts its countdown on that bit.
- DLL_LOCKING moves to DLL_LOCKED once its countdown reaches zero.

The power-down machine has the states PD_ACTIVE, PD_DOWN and PD_EXIT:
- PD_ACTIVE moves to PD_DOWN on a granted entry request.
- PD_DOWN moves to PD_EXIT on an exit request. At that point the exit countdown loads the fast-exit or the slow-exit time, as chosen by the stored exit-mode bit.
- PD_EXIT moves to PD_ACTIVE once its countdown reaches zero.

A request that arrives while its gate is closed is not acknowledged. It produces a one-cycle error pulse instead.

Top module: `mrs_timing_tracker`

## Requirements
- R1: `rd_lat` equals `al_cyc` plus the CAS latency. The CAS latency is the field at bits 6:4 plus 4, so codes 0..7 give 4..11 whole cycles. The value follows a register write from the next cycle.
- R2: A register write with bit 7 set drives `err_illegal_mode` high from the next cycle. It stays high until a later write clears bit 7.
- R3: Bit 8 (DLL reset) of `mr0_q` reads 1 for exactly one cycle after a write that sets it, then reads 0.
- R4: After a write with bit 8 set, `rd_ok` is low for exactly `t_dllk` cycles after that clock edge. It rises in the following cycle, provided power-down does not gate it.
- R5: From reset until the first DLL reset, a read or ODT request is not acknowledged. It gives a one-cycle `err_dll_noreset` pulse in the next cycle, with `err_timing` staying low.
- R6: With bit 12 at 0 (slow exit), a granted power-down exit holds `cmd_ok` low for `t_xpdll` cycles.
- R7: With bit 12 at 1 (fast exit), a granted power-down exit holds `cmd_ok` low for `t_xp` cycles.
- R8: The write-recovery field at bits 11:9 decodes as follows: codes 1..4 give 5..8 cycles, codes 5..7 give 10, 12 and 14 cycles, and code 0 gives 16. `err_wr_short` is high while the decoded value is below `wr_min`.
- R9: `wr2pre` equals the decoded write recovery plus `t_rp`.
- R10: These requests are not acknowledged: a read or ODT request during a DLL lock wait, a command, auto-precharge-write or power-down-entry request while `cmd_ok` is low, and an exit request outside power-down. Each gives a one-cycle `err_timing` pulse in the next cycle.
- R11: After reset, `rd_ok` is 0, `cmd_ok` is 1, all error flags are 0 and `mr0_q` is 0.
- R12: A power-down entry request is acknowledged in the same cycle when `cmd_ok` is high. `cmd_ok` and `rd_ok` then stay low until an exit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_valid | input | 1 | Mode-register write strobe |
| mrs_addr | input | 13 | Mode-register write value (address bits) |
| al_cyc | input | ALW | Additive latency in cycles |
| t_dllk | input | TW | DLL lock time in cycles |
| t_xp | input | TW | Fast power-down exit time in cycles |
| t_xpdll | input | TW | Slow power-down exit time in cycles |
| t_rp | input | TW | Precharge time in cycles |
| wr_min | input | TW | Minimum write recovery in cycles |
| req_rd | input | 1 | Read request |
| req_odt | input | 1 | Synchronous ODT request |
| req_pde | input | 1 | Power-down entry request |
| req_pdx | input | 1 | Power-down exit request |
| req_wrap | input | 1 | Auto-precharge write request |
| req_cmd | input | 1 | Any other command request |
| rd_lat | output | RLW | Read latency in cycles |
| wr2pre | output | TW+1 | Write-to-precharge delay in cycles |
| rd_ok | output | 1 | Read and ODT permitted |
| cmd_ok | output | 1 | Next command permitted |
| req_ack | output | 1 | A request this cycle is acknowledged |
| mr0_q | output | 13 | Stored mode-register value |
| err_illegal_mode | output | 1 | Test-mode bit is set |
| err_wr_short | output | 1 | Write recovery is below minimum |
| err_dll_noreset | output | 1 | Read or ODT before any DLL reset (pulse) |
| err_timing | output | 1 | Request made while gated (pulse) |

## Verification
A DLL machine stuck in the wrong state shows within one cycle of the next read request. It shows either as a missing acknowledge or as the wrong error pulse, `err_dll_noreset` versus `err_timing`. A countdown that loads the wrong value, or is off by one, changes the number of cycles that `rd_ok` or `cmd_ok` stays low, so the bench counts those cycles exactly. A power-down machine that fails to leave PD_DOWN keeps `cmd_ok` low indefinitely. One that skips PD_EXIT raises `cmd_ok` in the first cycle after the exit request.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    localparam int MR_W          = 13;
    localparam int MR_BIT_TEST   = 7;
    localparam int MR_BIT_DLLRST = 8;
    localparam int MR_BIT_FAST   = 12;
    localparam int CL_LSB        = 4;
    localparam int WR_LSB        = 9;

    typedef enum logic [1:0] {DLL_NEED_RST, DLL_LOCKING, DLL_LOCKED} dll_st_e;
    typedef enum logic [1:0] {PD_ACTIVE, PD_DOWN, PD_EXIT} pd_st_e;

    // CAS latency field: code + 4 cycles
    function automatic logic [3:0] cl_decode(input logic [2:0] code);
        return {1'b0, code} + 4'd4;
    endfunction

    // Write-recovery field: 1..4 -> 5..8, 5..7 -> 10..14, 0 -> 16
    function automatic logic [4:0] wr_decode(input logic [2:0] code);
        if (code == 3'd0)
            return 5'd16;
        else if (code <= 3'd4)
            return {2'b00, code} + 5'd4;
        else
            return {1'b0, code, 1'b0};
    endfunction
endpackage

// File: rtl/mrt_wait_cnt.sv
module mrt_wait_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/mrt_mr0_reg.sv
module mrt_mr0_reg
    import mrt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [MR_W-1:0] wr_data,
    output logic [MR_W-1:0] mr_q,
    output logic [3:0]      cl_cyc,
    output logic [4:0]      wr_cyc,
    output logic            test_mode,
    output logic            fast_exit
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            mr_q <= '0;
        else if (wr_en)
            mr_q <= wr_data;
        else if (mr_q[MR_BIT_DLLRST])
            mr_q[MR_BIT_DLLRST] <= 1'b0;   // self-clearing once issued
    end

    assign cl_cyc    = cl_decode(mr_q[CL_LSB +: 3]);
    assign wr_cyc    = wr_decode(mr_q[WR_LSB +: 3]);
    assign test_mode = mr_q[MR_BIT_TEST];
    assign fast_exit = mr_q[MR_BIT_FAST];
endmodule

// File: rtl/mrt_dll_fsm.sv
module mrt_dll_fsm
    import mrt_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_issue,
    input  logic [TW-1:0] t_lock,
    output logic          needs_rst,
    output logic          dll_ok
);
    dll_st_e state_q, state_d;
    logic    busy;

    mrt_wait_cnt #(.W(TW)) u_lock_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rst_issue),
        .load_val (t_lock),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DLL_NEED_RST;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLL_NEED_RST: if (rst_issue) state_d = DLL_LOCKING;
            DLL_LOCKING:  if (!rst_issue && !busy) state_d = DLL_LOCKED;
            DLL_LOCKED:   if (rst_issue) state_d = DLL_LOCKING;
            default:      state_d = DLL_NEED_RST;
        endcase
    end

    always_comb begin
        needs_rst = 1'b0;
        dll_ok    = 1'b0;
        unique case (state_q)
            DLL_NEED_RST: needs_rst = 1'b1;
            DLL_LOCKING:  dll_ok    = !busy;
            DLL_LOCKED:   dll_ok    = 1'b1;
            default:      needs_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/mrt_pd_fsm.sv
module mrt_pd_fsm
    import mrt_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_go,
    input  logic          exit_go,
    input  logic          fast_exit,
    input  logic [TW-1:0] t_xp,
    input  logic [TW-1:0] t_xpdll,
    output logic          cmd_ok,
    output logic          in_pd
);
    pd_st_e        state_q, state_d;
    logic          busy;
    logic [TW-1:0] exit_wait;

    assign exit_wait = fast_exit ? t_xp : t_xpdll;

    mrt_wait_cnt #(.W(TW)) u_exit_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exit_go),
        .load_val (exit_wait),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PD_ACTIVE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_ACTIVE: if (enter_go) state_d = PD_DOWN;
            PD_DOWN:   if (exit_go)  state_d = PD_EXIT;
            PD_EXIT:   if (!busy)    state_d = enter_go ? PD_DOWN : PD_ACTIVE;
            default:   state_d = PD_ACTIVE;
        endcase
    end

    always_comb begin
        cmd_ok = 1'b0;
        in_pd  = 1'b0;
        unique case (state_q)
            PD_ACTIVE: cmd_ok = 1'b1;
            PD_DOWN:   in_pd  = 1'b1;
            PD_EXIT:   cmd_ok = !busy;
            default:   cmd_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/mrs_timing_tracker.sv
module mrs_timing_tracker
    import mrt_pkg::*;
#(
    parameter int TW  = 10,
    parameter int ALW = 4,
    localparam int RLW = ((ALW > 4) ? ALW : 4) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mrs_valid,
    input  logic [MR_W-1:0] mrs_addr,
    input  logic [ALW-1:0]  al_cyc,
    input  logic [TW-1:0]   t_dllk,
    input  logic [TW-1:0]   t_xp,
    input  logic [TW-1:0]   t_xpdll,
    input  logic [TW-1:0]   t_rp,
    input  logic [TW-1:0]   wr_min,
    input  logic            req_rd,
    input  logic            req_odt,
    input  logic            req_pde,
    input  logic            req_pdx,
    input  logic            req_wrap,
    input  logic            req_cmd,
    output logic [RLW-1:0]  rd_lat,
    output logic [TW:0]     wr2pre,
    output logic            rd_ok,
    output logic            cmd_ok,
    output logic            req_ack,
    output logic [MR_W-1:0] mr0_q,
    output logic            err_illegal_mode,
    output logic            err_wr_short,
    output logic            err_dll_noreset,
    output logic            err_timing
);
    logic [3:0] cl_cyc;
    logic [4:0] wr_cyc;
    logic       fast_exit;
    logic       dll_rst_issue, dll_needs_rst, dll_ok, in_pd;
    logic       pde_go, pdx_go, rd_like, gen_cmd;
    logic       noreset_d, timing_d;

    assign dll_rst_issue = mrs_valid && mrs_addr[MR_BIT_DLLRST];

    mrt_mr0_reg u_mr0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mrs_valid),
        .wr_data   (mrs_addr),
        .mr_q      (mr0_q),
        .cl_cyc    (cl_cyc),
        .wr_cyc    (wr_cyc),
        .test_mode (err_illegal_mode),
        .fast_exit (fast_exit)
    );

    mrt_dll_fsm #(.TW(TW)) u_dll (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_issue (dll_rst_issue),
        .t_lock    (t_dllk),
        .needs_rst (dll_needs_rst),
        .dll_ok    (dll_ok)
    );

    mrt_pd_fsm #(.TW(TW)) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_go  (pde_go),
        .exit_go   (pdx_go),
        .fast_exit (fast_exit),
        .t_xp      (t_xp),
        .t_xpdll   (t_xpdll),
        .cmd_ok    (cmd_ok),
        .in_pd     (in_pd)
    );

    assign rd_lat       = RLW'(al_cyc) + RLW'(cl_cyc);
    assign wr2pre       = (TW+1)'(wr_cyc) + (TW+1)'(t_rp);
    assign err_wr_short = (TW'(wr_cyc) < wr_min);

    assign rd_ok   = dll_ok && cmd_ok;
    assign rd_like = req_rd || req_odt;
    assign gen_cmd = req_cmd || req_wrap || req_pde;
    assign pde_go  = req_pde && cmd_ok;
    assign pdx_go  = req_pdx && in_pd;
    assign req_ack = (rd_like && rd_ok) || (gen_cmd && cmd_ok) || pdx_go;

    assign noreset_d = rd_like && dll_needs_rst;
    assign timing_d  = (rd_like && !dll_needs_rst && !rd_ok) ||
                       (gen_cmd && !cmd_ok) ||
                       (req_pdx && !in_pd);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_dll_noreset <= 1'b0;
            err_timing      <= 1'b0;
        end else begin
            err_dll_noreset <= noreset_d;
            err_timing      <= timing_d;
        end
    end
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mrs_valid,
    input logic [12:0]   mrs_addr,
    input logic [TW-1:0] t_dllk,
    input logic [TW-1:0] t_xp,
    input logic [TW-1:0] t_xpdll,
    input logic          req_pdx,
    input logic          req_cmd,
    input logic          rd_ok,
    input logic          cmd_ok,
    input logic          req_ack,
    input logic [12:0]   mr0_q,
    input logic          err_illegal_mode,
    input logic          err_timing
);
    assert_test_mode_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_valid && mrs_addr[7] |=> err_illegal_mode);

    assert_dllrst_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mr0_q[8] && !mrs_valid |=> !mr0_q[8]);

    assert_lock_blocks_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_valid && mrs_addr[8] && (t_dllk != '0) |=> !rd_ok);

    assert_exit_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_pdx && req_ack && (t_xp != '0) && (t_xpdll != '0) |=> !cmd_ok);

    assert_gated_cmd_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_cmd && !cmd_ok |=> err_timing);
endmodule

bind mrs_timing_tracker mrt_checker #(.TW(TW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .mrs_valid        (mrs_valid),
    .mrs_addr         (mrs_addr),
    .t_dllk           (t_dllk),
    .t_xp             (t_xp),
    .t_xpdll          (t_xpdll),
    .req_pdx          (req_pdx),
    .req_cmd          (req_cmd),
    .rd_ok            (rd_ok),
    .cmd_ok           (cmd_ok),
    .req_ack          (req_ack),
    .mr0_q            (mr0_q),
    .err_illegal_mode (err_illegal_mode),
    .err_timing       (err_timing)
);

// File: tb/mrs_timing_tracker_tb.sv
module mrs_timing_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TW  = 10;
    localparam int ALW = 4;
    localparam int RLW = 5;
    localparam logic [12:0] BASE = 13'((4 << 9) | (3 << 4)); // WR code 4, CL code 3

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mrs_valid = 1'b0;
    logic [12:0] mrs_addr = '0;
    logic [ALW-1:0] al_cyc = 4'd2;
    logic [TW-1:0] t_dllk = 10'd8, t_xp = 10'd3, t_xpdll = 10'd6, t_rp = 10'd5, wr_min = 10'd8;
    logic req_rd = 0, req_odt = 0, req_pde = 0, req_pdx = 0, req_wrap = 0, req_cmd = 0;
    logic [RLW-1:0] rd_lat;
    logic [TW:0] wr2pre;
    logic rd_ok, cmd_ok, req_ack;
    logic [12:0] mr0_q;
    logic err_illegal_mode, err_wr_short, err_dll_noreset, err_timing;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrs_timing_tracker #(.TW(TW), .ALW(ALW)) u_dut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mrs(input logic [12:0] v);
        mrs_valid = 1'b1;
        mrs_addr  = v;
        step();
        mrs_valid = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R11 rd_ok", rd_ok, 0);
        chk("R11 cmd_ok", cmd_ok, 1);
        chk("R11 errors", {err_illegal_mode, err_wr_short, err_dll_noreset, err_timing}, 0);
        chk("R11 mr0_q", mr0_q, 0);
        chk("R1 rd_lat at reset", rd_lat, 6);
        chk("R9 wr2pre at reset", wr2pre, 21);
    endtask

    task automatic test_no_dll_reset();
        req_rd = 1'b1;
        #1 chk("R5 read ack", req_ack, 0);
        step();
        req_rd = 1'b0;
        chk("R5 noreset pulse", err_dll_noreset, 1);
        chk("R5 timing low", err_timing, 0);
        req_odt = 1'b1;
        step();
        req_odt = 1'b0;
        chk("R5 odt noreset", err_dll_noreset, 1);
        step();
        chk("R5 pulse ends", err_dll_noreset, 0);
    endtask

    task automatic test_dll_lock();
        int n;
        mrs(BASE | 13'h100);
        chk("R3 dllrst bit set", mr0_q[8], 1);
        chk("R4 rd_ok low", rd_ok, 0);
        n = 1;
        step();
        chk("R3 dllrst bit cleared", mr0_q[8], 0);
        while (!rd_ok && n < 50) begin n++; step(); end
        chk("R4 lock cycles", n, 8);
        chk("R1 rd_lat", rd_lat, 9);
        chk("R9 wr2pre", wr2pre, 13);
        chk("R8 no short", err_wr_short, 0);
        // relock, read during lock
        mrs(BASE | 13'h100);
        req_rd = 1'b1;
        #1 chk("R10 read ack while locking", req_ack, 0);
        step();
        req_rd = 1'b0;
        chk("R10 timing pulse", err_timing, 1);
        n = 0;
        while (!rd_ok && n < 50) begin n++; step(); end
        req_rd = 1'b1;
        #1 chk("R4 read ack after lock", req_ack, 1);
        step();
        req_rd = 1'b0;
        chk("R10 no pulse on grant", err_timing, 0);
    endtask

    task automatic test_write_recovery();
        mrs(13'((2 << 9) | (3 << 4)));
        chk("R8 code2 short", err_wr_short, 1);
        chk("R9 code2 wr2pre", wr2pre, 11);
        mrs(13'(3 << 4));
        chk("R8 code0 ok", err_wr_short, 0);
        chk("R9 code0 wr2pre", wr2pre, 21);
        mrs(13'((5 << 9) | (3 << 4)));
        chk("R9 code5 wr2pre", wr2pre, 15);
        mrs(13'((7 << 9) | (3 << 4)));
        chk("R9 code7 wr2pre", wr2pre, 19);
        mrs(BASE);
    endtask

    task automatic test_illegal();
        mrs(BASE | 13'h080);
        chk("R2 illegal set", err_illegal_mode, 1);
        step();
        chk("R2 illegal held", err_illegal_mode, 1);
        mrs(BASE);
        chk("R2 illegal cleared", err_illegal_mode, 0);
    endtask

    task automatic test_pd_slow();
        int n;
        req_pdx = 1'b1;
        #1 chk("R10 exit ack when active", req_ack, 0);
        step();
        req_pdx = 1'b0;
        chk("R10 exit outside pd", err_timing, 1);
        req_pde = 1'b1;
        #1 chk("R12 entry ack", req_ack, 1);
        step();
        req_pde = 1'b0;
        chk("R12 cmd_ok low", cmd_ok, 0);
        chk("R12 rd_ok low", rd_ok, 0);
        req_cmd = 1'b1;
        #1 chk("R10 cmd ack in pd", req_ack, 0);
        step();
        req_cmd = 1'b0;
        chk("R10 cmd in pd", err_timing, 1);
        req_pde = 1'b1;
        step();
        req_pde = 1'b0;
        chk("R10 entry in pd", err_timing, 1);
        req_pdx = 1'b1;
        #1 chk("R6 exit ack", req_ack, 1);
        step();
        req_pdx = 1'b0;
        n = 0;
        while (!cmd_ok && n < 50) begin n++; step(); end
        chk("R6 slow exit cycles", n, 6);
    endtask

    task automatic test_pd_fast();
        int n;
        mrs(BASE | 13'h1000);
        req_pde = 1'b1;
        step();
        req_pde = 1'b0;
        req_pdx = 1'b1;
        step();
        req_pdx = 1'b0;
        req_wrap = 1'b1;
        #1 chk("R10 wrap ack in exit", req_ack, 0);
        step();
        req_wrap = 1'b0;
        chk("R10 wrap in exit", err_timing, 1);
        n = 1;
        while (!cmd_ok && n < 50) begin n++; step(); end
        chk("R7 fast exit cycles", n, 3);
        chk("R12 rd_ok back", rd_ok, 1);
    endtask

    initial begin
        test_reset();
        test_no_dll_reset();
        test_dll_lock();
        test_write_recovery();
        test_illegal();
        test_pd_slow();
        test_pd_fast();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule